// File: doc/BRIEF.md
# Strap-Selected Slave Address and Control Register Block

This block is the register back end of an embedded two-wire serial slave. It works out the slave's own 7-bit address and holds the device's control registers. A 3-bit strap index comes from an external resistor-level sensor. It picks one of six addresses from a table that skips one code. Software can replace the strapped address with a programmed one by setting a select bit next to the stored address.

The bit-level serial engine sits in front of the block and reaches the registers through a byte-wide port. The register is addressed by `reg_addr` and written on a clock edge when `wr_en` is high. `rd_data` shows the addressed register combinationally.

Two self-clearing command bits give two reset scopes:
- One puts every register except the address register back to its default.
- The other pulses a logic reset output for a fixed number of cycles and leaves all register contents alone.

The block also provides:
- the pixel-clock edge select,
- I/O supply-level control with an auto-detect bypass,
- a clock-fallback enable,
- an 8-bit general-purpose output register,
- read-only status bits.

The parameter `RX_VARIANT` picks the receive-side or transmit-side address table and register placement.

Top module: `strap_reg_ctrl`

## Requirements
- R1: `slave_addr` is registered: it shows the new value one cycle after its inputs change. With override select 0 it equals BASE plus an offset taken from `strap_idx`:
  - indices 0 to 4 give offsets 0 to 4;
  - index 5 gives offset 6;
  - indices 6 and 7 give offset 0.
  BASE is 0x58 when `RX_VARIANT`=0 and 0x60 when `RX_VARIANT`=1.
- R2: Register 0x00 holds the programmed address in bits 7:1 and the override select in bit 0. The reset value is {BASE, 0}. When select is 1, `slave_addr` follows bits 7:1 one cycle later.
- R3: Writing register 0x01 with bit 1 set does two things. It restores registers 0x03 and the general-purpose register to their defaults on that same edge, and it leaves register 0x00 unchanged. Bit 1 reads back 1 for exactly one cycle after the write, then 0.
- R4: Writing register 0x01 with bit 0 set raises `logic_rst` for exactly LRST_CYCLES cycles (4 by default), starting the cycle after the write. Writing it again restarts the count. No register changes. Bit 0 reads 1 for one cycle only.
- R5: Register 0x03 bit 0 is the pixel-clock edge select. 1 means rising and 0 means falling. It resets to 1 and drives `edge_rise`.
- R6: Register 0x03 bit 5 is supply auto-detect (reset 1) and bit 4 is the manual supply level (reset 1 for transmit, 0 for receive). `io_3v3` equals `io_sense_hi` when bit 5 is 1, and bit 4 otherwise.
- R7: Register 0x03 bit 1 is the clock-fallback enable, reset 1, driving `clk_fb_en`. In the receive variant it is fixed at 0 and reads 0.
- R8: The general-purpose register sits at 0x13 (transmit) or 0x23 (receive). It resets to 0x00 and drives `gpo` bit for bit, with 1 meaning high.
- R9: Status is read-only:
  - transmit: 0x0C bit 2 = `link_ok`;
  - receive: 0x1C bit 1 = `sig_det` and bit 0 = `link_ok`.
  Writes to the status register have no effect.
- R10: Unimplemented addresses read 0x00, and writes to them change nothing. Unused bits of 0x01 (7:2) and 0x03 (7:6, 3:2) read 0.
- R11: `rd_data` reflects the register at `reg_addr` in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_idx | input | 3 | Decoded strap index from the resistor sensor |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| io_sense_hi | input | 1 | Detected I/O supply is the high level |
| link_ok | input | 1 | Lock / clock-present status |
| sig_det | input | 1 | Signal-detect status (receive variant) |
| slave_addr | output | 7 | Effective 7-bit slave address |
| gpo | output | 8 | General-purpose outputs |
| edge_rise | output | 1 | Pixel-clock edge select, 1 = rising |
| io_3v3 | output | 1 | Effective I/O supply level, 1 = high |
| clk_fb_en | output | 1 | Internal-oscillator fallback enable |
| logic_rst | output | 1 | Logic reset pulse |

## Verification
The bench builds two copies side by side from the same stimulus:
- `RX_VARIANT`=0 with LRST_CYCLES=4;
- `RX_VARIANT`=1 with LRST_CYCLES=4.

This lets it check both address tables and both register placements. It also shows that each variant's general-purpose and status addresses are unimplemented in the other. The four-cycle reset pulse stays short, so the bench can reach these cases within a few dozen cycles:
- restarting the pulse by rewriting the bit;
- overlapping a default restore with a logic reset;
- strap changes while the override is set.

// File: rtl/strap_reg_pkg.sv
package strap_reg_pkg;

    localparam int DW        = 8;
    localparam int SADDR_W   = 7;
    localparam int STRAP_W   = 3;

    localparam logic [7:0] REG_ID  = 8'h00;
    localparam logic [7:0] REG_RST = 8'h01;
    localparam logic [7:0] REG_CTL = 8'h03;

    typedef struct packed {
        logic [SADDR_W-1:0] prog;
        logic               sel;
    } id_reg_t;

    typedef struct packed {
        logic vauto;
        logic vmode;
        logic clk_fb;
        logic edge_r;
    } ctl_reg_t;

    typedef enum logic {SRC_STRAP = 1'b0, SRC_PROG = 1'b1} addr_src_e;

    function automatic logic [SADDR_W-1:0] base_addr(input bit rx);
        return rx ? 7'h60 : 7'h58;
    endfunction

    function automatic logic [SADDR_W-1:0] strap_offset(input logic [STRAP_W-1:0] idx);
        logic [SADDR_W-1:0] off;
        case (idx)
            3'd0, 3'd1, 3'd2, 3'd3, 3'd4: off = SADDR_W'(idx);
            3'd5:                         off = 7'd6;
            default:                      off = 7'd0;
        endcase
        return off;
    endfunction

    function automatic logic [7:0] gpo_reg(input bit rx);
        return rx ? 8'h23 : 8'h13;
    endfunction

    function automatic logic [7:0] stat_reg(input bit rx);
        return rx ? 8'h1C : 8'h0C;
    endfunction

    function automatic ctl_reg_t ctl_default(input bit rx);
        ctl_reg_t c;
        c.vauto  = 1'b1;
        c.vmode  = rx ? 1'b0 : 1'b1;
        c.clk_fb = rx ? 1'b0 : 1'b1;
        c.edge_r = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/strap_addr_sel.sv
module strap_addr_sel
    import strap_reg_pkg::*;
#(
    parameter bit RX_VARIANT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [STRAP_W-1:0]   strap_idx,
    input  id_reg_t              id_q,
    output logic [SADDR_W-1:0]   slave_addr
);
    localparam logic [SADDR_W-1:0] BASE = base_addr(RX_VARIANT);

    addr_src_e                src;
    logic [SADDR_W-1:0]       strap_addr;
    logic [SADDR_W-1:0]       next_addr;

    always_comb begin
        src        = id_q.sel ? SRC_PROG : SRC_STRAP;
        strap_addr = BASE + strap_offset(strap_idx);
        next_addr  = (src == SRC_PROG) ? id_q.prog : strap_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) slave_addr <= BASE;
        else     slave_addr <= next_addr;
    end

    // R2: override tracks the programmed address one cycle later
    a_r2_override_follows: assert property (@(posedge clk) disable iff (rst)
        id_q.sel |=> slave_addr == $past(id_q.prog));

    // R1: strap-derived address stays inside the six-entry table
    a_r1_table_legal: assert property (@(posedge clk) disable iff (rst)
        !id_q.sel |=> (slave_addr[6:3] == BASE[6:3]) && (slave_addr[2:0] != 3'd5)
                      && (slave_addr[2:0] != 3'd7));
endmodule

// File: rtl/sc_reset_ctl.sv
module sc_reset_ctl
    import strap_reg_pkg::*;
#(
    parameter int LRST_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic [1:0] cmd,
    output logic [1:0] sc_q,
    output logic       def_restore,
    output logic       logic_rst
);
    localparam int CW = $clog2(LRST_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          load;

    assign load        = hit & cmd[0];
    assign def_restore = hit & cmd[1];
    assign logic_rst   = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_q  <= 2'b00;
            cnt_q <= '0;
        end else begin
            sc_q <= hit ? cmd : 2'b00;
            if (load)              cnt_q <= CW'(LRST_CYCLES);
            else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
        end
    end

    // R4: a logic-reset command raises the pulse on the next cycle
    a_r4_pulse_start: assert property (@(posedge clk) disable iff (rst)
        load |=> logic_rst);

    // R4: the pulse never starts without a command
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!logic_rst && !load) |=> !logic_rst);

    // R3: the restore command bit clears itself after one cycle
    a_r3_selfclear: assert property (@(posedge clk) disable iff (rst)
        (sc_q[1] && !def_restore) |=> !sc_q[1]);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import strap_reg_pkg::*;
#(
    parameter bit RX_VARIANT = 1'b0,
    parameter int AW         = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic           def_restore,
    input  logic [1:0]     sc_q,
    input  logic           link_ok,
    input  logic           sig_det,
    output id_reg_t        id_q,
    output ctl_reg_t       ctl_q,
    output logic [DW-1:0]  gpo_q,
    output logic [DW-1:0]  rd_data
);
    localparam ctl_reg_t     CTL_DEF = ctl_default(RX_VARIANT);
    localparam id_reg_t      ID_DEF  = '{prog: base_addr(RX_VARIANT), sel: 1'b0};
    localparam logic [AW-1:0] A_ID   = AW'(REG_ID);
    localparam logic [AW-1:0] A_RST  = AW'(REG_RST);
    localparam logic [AW-1:0] A_CTL  = AW'(REG_CTL);
    localparam logic [AW-1:0] A_GPO  = AW'(gpo_reg(RX_VARIANT));
    localparam logic [AW-1:0] A_STAT = AW'(stat_reg(RX_VARIANT));

    logic [DW-1:0] stat_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q  <= ID_DEF;
            ctl_q <= CTL_DEF;
            gpo_q <= '0;
        end else if (def_restore) begin
            ctl_q <= CTL_DEF;
            gpo_q <= '0;
        end else if (wr_en) begin
            if (reg_addr == A_ID) begin
                id_q <= id_reg_t'(wr_data);
            end else if (reg_addr == A_CTL) begin
                ctl_q.vauto  <= wr_data[5];
                ctl_q.vmode  <= wr_data[4];
                ctl_q.clk_fb <= RX_VARIANT ? 1'b0 : wr_data[1];
                ctl_q.edge_r <= wr_data[0];
            end else if (reg_addr == A_GPO) begin
                gpo_q <= wr_data;
            end
        end
    end

    generate
        if (RX_VARIANT) begin : g_rx_stat
            assign stat_val = {6'b0, sig_det, link_ok};
        end else begin : g_tx_stat
            logic unused_sig;
            assign unused_sig = sig_det;
            assign stat_val   = {5'b0, link_ok, 2'b0};
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if      (reg_addr == A_ID)   rd_data = id_q;
        else if (reg_addr == A_RST)  rd_data = {6'b0, sc_q};
        else if (reg_addr == A_CTL)  rd_data = {2'b0, ctl_q.vauto, ctl_q.vmode,
                                                2'b0, ctl_q.clk_fb, ctl_q.edge_r};
        else if (reg_addr == A_GPO)  rd_data = gpo_q;
        else if (reg_addr == A_STAT) rd_data = stat_val;
    end

    // R3: the default restore leaves the address register untouched
    a_r3_addr_kept: assert property (@(posedge clk) disable iff (rst)
        def_restore |=> $stable(id_q));

    // R8: the default restore clears the general-purpose outputs
    a_r8_gpo_cleared: assert property (@(posedge clk) disable iff (rst)
        def_restore |=> gpo_q == '0);

    // R5: the default restore returns the edge select to rising
    a_r5_edge_default: assert property (@(posedge clk) disable iff (rst)
        def_restore |=> ctl_q.edge_r);

    // R7: receive variant never enables clock fallback
    a_r7_rx_no_fallback: assert property (@(posedge clk) disable iff (rst)
        RX_VARIANT |-> !ctl_q.clk_fb);
endmodule

// File: rtl/strap_reg_ctrl.sv
module strap_reg_ctrl
    import strap_reg_pkg::*;
#(
    parameter bit RX_VARIANT  = 1'b0,
    parameter int LRST_CYCLES = 4,
    parameter int AW          = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    strap_idx,
    input  logic          wr_en,
    input  logic [AW-1:0] reg_addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data,
    input  logic          io_sense_hi,
    input  logic          link_ok,
    input  logic          sig_det,
    output logic [6:0]    slave_addr,
    output logic [7:0]    gpo,
    output logic          edge_rise,
    output logic          io_3v3,
    output logic          clk_fb_en,
    output logic          logic_rst
);
    id_reg_t  id_q;
    ctl_reg_t ctl_q;
    logic [1:0] sc_q;
    logic       def_restore;
    logic       rst_hit;

    assign rst_hit = wr_en && (reg_addr == AW'(REG_RST));

    sc_reset_ctl #(.LRST_CYCLES(LRST_CYCLES)) u_sc (
        .clk         (clk),
        .rst         (rst),
        .hit         (rst_hit),
        .cmd         (wr_data[1:0]),
        .sc_q        (sc_q),
        .def_restore (def_restore),
        .logic_rst   (logic_rst)
    );

    cfg_regfile #(.RX_VARIANT(RX_VARIANT), .AW(AW)) u_rf (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .reg_addr    (reg_addr),
        .wr_data     (wr_data),
        .def_restore (def_restore),
        .sc_q        (sc_q),
        .link_ok     (link_ok),
        .sig_det     (sig_det),
        .id_q        (id_q),
        .ctl_q       (ctl_q),
        .gpo_q       (gpo),
        .rd_data     (rd_data)
    );

    strap_addr_sel #(.RX_VARIANT(RX_VARIANT)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .strap_idx  (strap_idx),
        .id_q       (id_q),
        .slave_addr (slave_addr)
    );

    assign edge_rise = ctl_q.edge_r;
    assign clk_fb_en = ctl_q.clk_fb;
    assign io_3v3    = ctl_q.vauto ? io_sense_hi : ctl_q.vmode;

    // R6: with auto-detect off the supply level follows the manual bit
    a_r6_manual_level: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.vauto && $stable(ctl_q)) |-> io_3v3 == ctl_q.vmode);
endmodule

// File: tb/sim_strap_reg_ctrl.sv
`timescale 1ns/1ps
module sim_strap_reg_ctrl;
    localparam int LR = 4;

    logic clk = 0, rst = 1;
    logic [2:0] strap_idx = 0;
    logic wr_en = 0;
    logic [7:0] reg_addr = 0, wr_data = 0;
    logic io_sense_hi = 1, link_ok = 0, sig_det = 0;

    logic [7:0] rd0, rd1, gpo0, gpo1;
    logic [6:0] sa0, sa1;
    logic er0, er1, io0, io1, fb0, fb1, lr0, lr1;

    always #2.5 clk = ~clk;

    strap_reg_ctrl #(.RX_VARIANT(1'b0), .LRST_CYCLES(LR)) u0 (
        .clk(clk), .rst(rst), .strap_idx(strap_idx), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd0), .io_sense_hi(io_sense_hi), .link_ok(link_ok),
        .sig_det(sig_det), .slave_addr(sa0), .gpo(gpo0), .edge_rise(er0), .io_3v3(io0),
        .clk_fb_en(fb0), .logic_rst(lr0));

    strap_reg_ctrl #(.RX_VARIANT(1'b1), .LRST_CYCLES(LR)) u1 (
        .clk(clk), .rst(rst), .strap_idx(strap_idx), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd1), .io_sense_hi(io_sense_hi), .link_ok(link_ok),
        .sig_det(sig_det), .slave_addr(sa1), .gpo(gpo1), .edge_rise(er1), .io_3v3(io1),
        .clk_fb_en(fb1), .logic_rst(lr1));

    int total = 0, bad = 0, cyc = 0;
    bit done = 0, m_valid = 0;

    // reference model state, index 0 = transmit, 1 = receive
    logic [6:0] m_prog[2], m_saddr[2];
    logic       m_sel[2], m_va[2], m_vm[2], m_fb[2], m_er[2];
    logic [7:0] m_gpo[2];
    logic [1:0] m_sc[2];
    int         m_lc[2];

    function automatic logic [6:0] f_base(int v); return (v != 0) ? 7'h60 : 7'h58; endfunction
    function automatic logic [6:0] f_off(logic [2:0] i);
        if (i <= 3'd4) return {4'b0, i};
        if (i == 3'd5) return 7'd6;
        return 7'd0;
    endfunction
    function automatic logic [7:0] f_gaddr(int v); return (v != 0) ? 8'h23 : 8'h13; endfunction
    function automatic logic [7:0] f_saddr(int v); return (v != 0) ? 8'h1C : 8'h0C; endfunction

    function automatic logic [7:0] exp_rd(int v);
        if (reg_addr == 8'h00) return {m_prog[v], m_sel[v]};
        if (reg_addr == 8'h01) return {6'b0, m_sc[v]};
        if (reg_addr == 8'h03) return {2'b0, m_va[v], m_vm[v], 2'b0, m_fb[v], m_er[v]};
        if (reg_addr == f_gaddr(v)) return m_gpo[v];
        if (reg_addr == f_saddr(v))
            return (v != 0) ? {6'b0, sig_det, link_ok} : {5'b0, link_ok, 2'b0};
        return 8'h00;
    endfunction

    task automatic restore_ctl(int v);
        m_va[v] = 1; m_vm[v] = (v == 0); m_fb[v] = (v == 0); m_er[v] = 1; m_gpo[v] = 0;
    endtask

    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            if (rst) begin
                m_prog[v] = f_base(v); m_sel[v] = 0; restore_ctl(v);
                m_sc[v] = 0; m_lc[v] = 0; m_saddr[v] = f_base(v);
                m_valid = 1;
            end else begin
                logic [6:0] nsa;
                nsa = m_sel[v] ? m_prog[v] : f_base(v) + f_off(strap_idx);
                if (m_lc[v] > 0) m_lc[v]--;
                m_sc[v] = 0;
                if (wr_en) begin
                    if (reg_addr == 8'h00) begin
                        m_prog[v] = wr_data[7:1]; m_sel[v] = wr_data[0];
                    end else if (reg_addr == 8'h01) begin
                        m_sc[v] = wr_data[1:0];
                        if (wr_data[0]) m_lc[v] = LR;
                        if (wr_data[1]) restore_ctl(v);
                    end else if (reg_addr == 8'h03) begin
                        m_va[v] = wr_data[5]; m_vm[v] = wr_data[4];
                        m_fb[v] = (v == 0) ? wr_data[1] : 1'b0; m_er[v] = wr_data[0];
                    end else if (reg_addr == f_gaddr(v)) begin
                        m_gpo[v] = wr_data;
                    end
                end
                m_saddr[v] = nsa;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (m_valid && !done) begin
            chk("R11 rd tx", rd0, exp_rd(0));        chk("R11 rd rx", rd1, exp_rd(1));
            chk("R1 R2 addr tx", sa0, m_saddr[0]);   chk("R1 R2 addr rx", sa1, m_saddr[1]);
            chk("R8 gpo tx", gpo0, m_gpo[0]);        chk("R8 gpo rx", gpo1, m_gpo[1]);
            chk("R5 edge tx", er0, m_er[0]);         chk("R5 edge rx", er1, m_er[1]);
            chk("R6 io tx", io0, m_va[0] ? io_sense_hi : m_vm[0]);
            chk("R6 io rx", io1, m_va[1] ? io_sense_hi : m_vm[1]);
            chk("R7 fb tx", fb0, m_fb[0]);           chk("R7 fb rx", fb1, m_fb[1]);
            chk("R4 lrst tx", lr0, m_lc[0] > 0);     chk("R4 lrst rx", lr1, m_lc[1] > 0);
        end
        if (cyc > 150000 && !done) begin
            done = 1; bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(posedge clk); #1; wr_en = 1; reg_addr = a; wr_data = d;
        @(posedge clk); #1; wr_en = 0;
    endtask

    logic [7:0] pick[8] = '{8'h00, 8'h01, 8'h03, 8'h0C, 8'h13, 8'h1C, 8'h23, 8'h05};

    initial begin
        strap_idx = 3'd5;
        tick(3); rst = 0; tick(2);
        // R1 strap index 5 skips to offset 6
        chk("R1 strap5 tx", sa0, 7'h5E); chk("R1 strap5 rx", sa1, 7'h66);
        strap_idx = 3'd7; tick(2);
        chk("R1 strap7 tx", sa0, 7'h58); chk("R1 strap7 rx", sa1, 7'h60);
        for (int i = 0; i < 6; i++) begin strap_idx = 3'(i); tick(1); end
        reg_addr = 8'h00; #1;
        chk("R2 reset id tx", rd0, 8'hB0); chk("R2 reset id rx", rd1, 8'hC0);
        reg_addr = 8'h03; #1;
        chk("R5 R6 R7 ctl tx", rd0, 8'h33); chk("R5 R6 R7 ctl rx", rd1, 8'h21);
        wr(8'h00, 8'hA5); tick(1);
        chk("R2 override tx", sa0, 7'h52); chk("R2 override rx", sa1, 7'h52);
        wr(8'h13, 8'h3C);
        chk("R8 gpo tx", gpo0, 8'h3C); chk("R10 foreign gpo rx", gpo1, 8'h00);
        reg_addr = 8'h13; #1; chk("R10 unimpl read rx", rd1, 8'h00);
        wr(8'h03, 8'h10); io_sense_hi = 0; #1;
        chk("R6 manual hi tx", io0, 1'b1); chk("R5 falling tx", er0, 1'b0);
        // R3 default restore: reads 1 once, address kept
        wr(8'h01, 8'h02); reg_addr = 8'h01; #1;
        chk("R3 sc read tx", rd0, 8'h02);
        tick(1); chk("R3 sc cleared tx", rd0, 8'h00);
        reg_addr = 8'h03; #1; chk("R3 ctl restored tx", rd0, 8'h33);
        reg_addr = 8'h00; #1; chk("R3 id kept tx", rd0, 8'hA5);
        chk("R3 gpo restored tx", gpo0, 8'h00);
        wr(8'h23, 8'h81);
        // R4 logic reset pulse of LR cycles, registers retained
        wr(8'h01, 8'h01);
        for (int i = 0; i < LR; i++) begin chk("R4 pulse high rx", lr1, 1'b1); tick(1); end
        chk("R4 pulse end rx", lr1, 1'b0); chk("R4 regs kept rx", gpo1, 8'h81);
        wr(8'h01, 8'h01); tick(1); wr(8'h01, 8'h03);
        for (int i = 0; i < LR; i++) begin chk("R4 restart tx", lr0, 1'b1); tick(1); end
        chk("R4 restart end tx", lr0, 1'b0);
        // R9 status read-only
        link_ok = 1; sig_det = 0; wr(8'h1C, 8'hFF); wr(8'h0C, 8'hFF);
        reg_addr = 8'h1C; #1; chk("R9 stat rx", rd1, 8'h01); chk("R10 0x1C tx", rd0, 8'h00);
        reg_addr = 8'h0C; #1; chk("R9 stat tx", rd0, 8'h04);
        wr(8'h05, 8'hFF); reg_addr = 8'h05; #1; chk("R10 unimpl tx", rd0, 8'h00);
        // random phase, model-compared every cycle
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            rst = ($urandom % 300) == 0;
            wr_en = ($urandom % 3) == 0;
            reg_addr = pick[$urandom % 8];
            wr_data = 8'($urandom);
            strap_idx = 3'($urandom);
            io_sense_hi = 1'($urandom); link_ok = 1'($urandom); sig_det = 1'($urandom);
        end
        rst = 0; wr_en = 0; tick(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule